// File: doc/BRIEF.md
# Wakeup interrupt sense converter

This block sits between a set of raw interrupt lines and a downstream controller that only accepts two request forms: a level that is high while active, and a rising edge. Each line has a three-bit trigger code and an enable bit. The block synchronizes every line to its clock and then normalizes it. Active-low levels come out inverted. A falling edge becomes a one-cycle pulse, as does a rising edge, and a line set for both edges pulses on each transition. The controller therefore never has to handle polarity or edge type.

Software programs the block through a word-granular register port with byte addresses. A bank of enable words holds 32 line enables per word. It is followed by a run of per-line trigger words, one word for each line. Polarity is applied before edge detection. Rewriting a line's trigger code while its input is steady can therefore make the normalized signal jump. The block blanks edge requests for one cycle after any write that changes a line's code, so such a rewrite never produces a false event.

Top module: `wake_sense_conv`

## Requirements
- R1: After reset every enable bit and every trigger code is zero, every request output is low and every mapped register reads 0.
- R2: Line n's enable is bit n&31 of the enable word at byte address 0x10 + 4*(n>>5). Line n's trigger code is bits [2:0] of the word at 0x110 + 4*n, and the upper bits of that word read 0. Enable bits for lines that do not exist read 0. A write to an unmapped address changes nothing, and an unmapped address reads 0.
- R3: With code 3'b100 (level, active high) and the line enabled, the request equals the synchronized input level.
- R4: With code 3'b000 (level, active low) and the line enabled, the request equals the inverse of the synchronized input level.
- R5: With code 3'b110 (rising edge) and the line enabled, each low-to-high input transition gives a request pulse exactly one cycle wide, and a high-to-low transition gives none.
- R6: With code 3'b010 (falling edge) and the line enabled, each high-to-low input transition gives a one-cycle request pulse, and a low-to-high transition gives none.
- R7: With code 3'b111 (both edges) and the line enabled, each input transition in either direction gives a one-cycle request pulse.
- R8: A line whose enable bit is 0 holds its request low, whatever its input or code.
- R9: The undefined codes 3'b001, 3'b011 and 3'b101 hold the request low, whatever the input.
- R10: If a write changes a line's trigger code, no edge request comes from the cycle that follows. In particular, swapping polarity while the input is steady produces no pulse.
- R11: An input change first shows at the request output after the third rising clock edge from the edge that samples it. That latency comes from a two-flop synchronizer followed by a registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| line_i | input | NUM_LINES | Raw asynchronous interrupt lines |
| req_o | output | NUM_LINES | Normalized requests to the downstream controller |

## Verification
The bench builds the block with NUM_LINES set to 40, ADDR_W set to 12, SYNC_STAGES set to 2 and the default register bases. Forty lines need a second enable word that is only one quarter populated. This exposes the word and bit split of the line number, as well as the read-as-zero bits for lines that do not exist. One line is used in the first word and one in the second. With only a few lines in play, every trigger code, every polarity swap on a steady input and the exact three-edge latency can each be exercised directly.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

   localparam int REG_W  = 32;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      TRG_LVL_LOW   = 3'b000,
      TRG_EDGE_FALL = 3'b010,
      TRG_LVL_HIGH  = 3'b100,
      TRG_EDGE_RISE = 3'b110,
      TRG_EDGE_BOTH = 3'b111
   } trig_e;

   typedef struct packed {
      logic valid;
      logic invert;
      logic edge_mode;
      logic both;
   } trig_dec_t;

   function automatic trig_dec_t decode_trig(input logic [CODE_W-1:0] code);
      trig_dec_t d;
      d = '0;
      case (code)
         TRG_LVL_LOW:   begin d.valid = 1'b1; d.invert = 1'b1; end
         TRG_EDGE_FALL: begin d.valid = 1'b1; d.invert = 1'b1; d.edge_mode = 1'b1; end
         TRG_LVL_HIGH:  begin d.valid = 1'b1; end
         TRG_EDGE_RISE: begin d.valid = 1'b1; d.edge_mode = 1'b1; end
         TRG_EDGE_BOTH: begin d.valid = 1'b1; d.edge_mode = 1'b1; d.both = 1'b1; end
         default:       d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("wsc_sync: STAGES must be at least 2");
      end

      if (STAGES == 2) begin : g_two
         logic [WIDTH-1:0] meta_q;
         logic [WIDTH-1:0] safe_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               meta_q <= '0;
               safe_q <= '0;
            end else begin
               meta_q <= d_i;
               safe_q <= meta_q;
            end
         end
         assign q_o = safe_q;
      end else begin : g_chain
         logic [WIDTH-1:0] chain_q [STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wsc_regs.sv
module wsc_regs
   import wsc_pkg::*;
#(
   parameter int NUM_LINES = 168,
   parameter int ADDR_W    = 12,
   parameter int ENB_BASE  = 'h10,
   parameter int CFG_BASE  = 'h110
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        we_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [REG_W-1:0]            wdata_i,
   output logic [REG_W-1:0]            rdata_o,
   output logic [NUM_LINES-1:0]        en_o,
   output logic [NUM_LINES*CODE_W-1:0] cfg_o,
   output logic [NUM_LINES-1:0]        chg_o
);

   localparam int NUM_WORDS = (NUM_LINES + REG_W - 1) / REG_W;
   localparam int WA        = ADDR_W - 2;
   localparam int ENB_W0    = ENB_BASE / 4;
   localparam int CFG_W0    = CFG_BASE / 4;

   logic [WA-1:0]       widx;
   logic [1:0]          unused_byte_sel;
   logic [NUM_LINES-1:0] en_q;
   logic [CODE_W-1:0]   cfg_q [NUM_LINES];
   logic [NUM_LINES-1:0] chg_q;

   assign widx            = addr_i[ADDR_W-1:2];
   assign unused_byte_sel = addr_i[1:0];

   generate
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         localparam int WI = l / REG_W;
         localparam int BI = l % REG_W;
         logic en_hit;
         logic cfg_hit;

         assign en_hit  = we_i && (int'(widx) == ENB_W0 + WI);
         assign cfg_hit = we_i && (int'(widx) == CFG_W0 + l);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               en_q[l]  <= 1'b0;
               cfg_q[l] <= '0;
               chg_q[l] <= 1'b0;
            end else begin
               if (en_hit)  en_q[l]  <= wdata_i[BI];
               if (cfg_hit) cfg_q[l] <= wdata_i[CODE_W-1:0];
               chg_q[l] <= cfg_hit && (wdata_i[CODE_W-1:0] != cfg_q[l]);
            end
         end

         assign cfg_o[l*CODE_W +: CODE_W] = cfg_q[l];

         AST_BLANK_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            chg_q[l] == (cfg_q[l] != $past(cfg_q[l]))); // R10
         AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !we_i |=> ($stable(cfg_q[l]) && $stable(en_q[l]))); // R2
      end
   endgenerate

   assign en_o  = en_q;
   assign chg_o = chg_q;

   always_comb begin
      rdata_o = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (int'(widx) == ENB_W0 + w) begin
            for (int b = 0; b < REG_W; b++) begin
               if (w * REG_W + b < NUM_LINES) rdata_o[b] = en_q[w * REG_W + b];
            end
         end
      end
      for (int l = 0; l < NUM_LINES; l++) begin
         if (int'(widx) == CFG_W0 + l) rdata_o = {{(REG_W-CODE_W){1'b0}}, cfg_q[l]};
      end
   end

endmodule

// File: rtl/wsc_lane.sv
module wsc_lane
   import wsc_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sync_i,
   input  logic              en_i,
   input  logic [CODE_W-1:0] cfg_i,
   input  logic              blank_i,
   output logic              req_o
);

   trig_dec_t dec;
   logic      norm;
   logic      norm_prev_q;
   logic      edge_hit;
   logic      req_d;
   logic      req_q;

   assign dec      = decode_trig(cfg_i);
   assign norm     = sync_i ^ dec.invert;
   assign edge_hit = dec.both ? (norm ^ norm_prev_q) : (norm & ~norm_prev_q);
   assign req_d    = en_i & dec.valid &
                     (dec.edge_mode ? (edge_hit & ~blank_i) : norm);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         norm_prev_q <= 1'b0;
         req_q       <= 1'b0;
      end else begin
         norm_prev_q <= norm;
         req_q       <= req_d;
      end
   end

   assign req_o = req_q;

   AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !req_o); // R8
   AST_UNDEF_CODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i inside {3'b001, 3'b011, 3'b101}) |=> !req_o); // R9
   AST_LEVEL_HIGH_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cfg_i == TRG_LVL_HIGH) |=> (req_o == $past(sync_i))); // R3
   AST_LEVEL_LOW_INVERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cfg_i == TRG_LVL_LOW) |=> (req_o == !$past(sync_i))); // R4
   AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cfg_i == TRG_EDGE_RISE || cfg_i == TRG_EDGE_FALL) && req_o) |=> !req_o); // R5
   AST_NO_PHANTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank_i && cfg_i[1]) |=> !req_o); // R10

endmodule

// File: rtl/wake_sense_conv.sv
module wake_sense_conv
   import wsc_pkg::*;
#(
   parameter int NUM_LINES   = 168,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int ENB_BASE    = 'h10,
   parameter int CFG_BASE    = 'h110
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 reg_we_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic [31:0]          reg_wdata_i,
   output logic [31:0]          reg_rdata_o,
   input  logic [NUM_LINES-1:0] line_i,
   output logic [NUM_LINES-1:0] req_o
);

   localparam int NUM_WORDS = (NUM_LINES + REG_W - 1) / REG_W;
   localparam int ENB_END   = ENB_BASE + 4 * NUM_WORDS;
   localparam int CFG_END   = CFG_BASE + 4 * NUM_LINES;

   generate
      if (NUM_LINES < 1 || NUM_LINES > 1024) begin : g_chk_lines
         $error("wake_sense_conv: NUM_LINES out of range");
      end
      if ((ENB_BASE % 4) != 0 || (CFG_BASE % 4) != 0) begin : g_chk_align
         $error("wake_sense_conv: register bases must be word aligned");
      end
      if (ENB_END > CFG_BASE) begin : g_chk_overlap
         $error("wake_sense_conv: enable bank overlaps trigger words");
      end
      if (CFG_END > (1 << ADDR_W)) begin : g_chk_addr
         $error("wake_sense_conv: ADDR_W too small for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("wake_sense_conv: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_LINES-1:0]        line_s;
   logic [NUM_LINES-1:0]        en;
   logic [NUM_LINES*CODE_W-1:0] cfg;
   logic [NUM_LINES-1:0]        chg;

   wsc_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_i),
      .q_o    (line_s)
   );

   wsc_regs #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W),
      .ENB_BASE  (ENB_BASE),
      .CFG_BASE  (CFG_BASE)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .rdata_o (reg_rdata_o),
      .en_o    (en),
      .cfg_o   (cfg),
      .chg_o   (chg)
   );

   generate
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_lane
         wsc_lane u_lane (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .sync_i  (line_s[l]),
            .en_i    (en[l]),
            .cfg_i   (cfg[l*CODE_W +: CODE_W]),
            .blank_i (chg[l]),
            .req_o   (req_o[l])
         );
      end
   endgenerate

endmodule

// File: tb/wake_sense_conv_test.sv
module wake_sense_conv_test;

   localparam int N  = 40;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  lines = '0;
   logic [N-1:0]  req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   wake_sense_conv #(.NUM_LINES(N), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
      .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .line_i(lines), .req_o(req)
   );

   function automatic logic [AW-1:0] cfg_addr(input int l);
      return AW'('h110 + 4 * l);
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic drive_watch(input int l, input logic v, input logic e1, input logic e2,
                              input logic e3, input string tag);
      @(negedge clk);
      lines[l] = v;
      @(negedge clk);
      @(negedge clk);
      chk(tag, "before third edge", 32'(req[l]), 32'(e1));
      @(negedge clk);
      chk(tag, "after third edge", 32'(req[l]), 32'(e2));
      @(negedge clk);
      chk(tag, "one cycle later", 32'(req[l]), 32'(e3));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1", "req after reset", 32'(req), 32'h0);
      rd(AW'('h10), d);  chk("R1", "enable word 0", d, 32'h0);
      rd(AW'('h14), d);  chk("R1", "enable word 1", d, 32'h0);
      rd(cfg_addr(3), d); chk("R1", "trigger word 3", d, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(AW'('h14), 32'hFFFF_FFFF);
      rd(AW'('h14), d);  chk("R2", "enable word 1 populated bits", d, 32'h0000_00FF);
      repeat (2) @(negedge clk);
      chk("R2", "line 37 active-low idle via word 1 bit 5", 32'(req[37]), 32'h1);
      wr(cfg_addr(5), 32'hFFFF_FFFF);
      rd(cfg_addr(5), d); chk("R2", "trigger word upper bits", d, 32'h7);
      wr(AW'('h000), 32'hFFFF_FFFF);
      rd(AW'('h000), d); chk("R2", "unmapped read", d, 32'h0);
      rd(AW'('h18), d);  chk("R2", "absent enable word", d, 32'h0);
      rd(AW'('h10), d);  chk("R2", "unmapped write left word 0", d, 32'h0);
      wr(AW'('h14), 32'h0);
      wr(cfg_addr(5), 32'h0);
      rd(cfg_addr(5), d); chk("R2", "trigger word cleared", d, 32'h0);
   endtask

   task automatic t_level_low();
      wr(AW'('h14), 32'h20);
      settle();
      chk("R4", "low input gives high request", 32'(req[37]), 32'h1);
      drive_watch(37, 1'b1, 1'b1, 1'b0, 1'b0, "R4 R11");
      drive_watch(37, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
      wr(AW'('h14), 32'h0);
   endtask

   task automatic t_level_high();
      wr(cfg_addr(3), 32'h4);
      wr(AW'('h10), 32'h8);
      settle();
      chk("R3", "low input", 32'(req[3]), 32'h0);
      drive_watch(3, 1'b1, 1'b0, 1'b1, 1'b1, "R3 R11");
      drive_watch(3, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
   endtask

   task automatic t_disabled();
      drive_watch(3, 1'b1, 1'b0, 1'b1, 1'b1, "R8 setup");
      wr(AW'('h10), 32'h0);
      @(negedge clk);
      chk("R8", "disabled high level", 32'(req[3]), 32'h0);
      wr(cfg_addr(3), 32'h7);
      drive_watch(3, 1'b0, 1'b0, 1'b0, 1'b0, "R8 disabled edge");
   endtask

   task automatic t_rising();
      wr(cfg_addr(3), 32'h6);
      wr(AW'('h10), 32'h8);
      settle();
      drive_watch(3, 1'b1, 1'b0, 1'b1, 1'b0, "R5 rise");
      drive_watch(3, 1'b0, 1'b0, 1'b0, 1'b0, "R5 fall");
   endtask

   task automatic t_falling();
      wr(cfg_addr(3), 32'h2);
      settle();
      drive_watch(3, 1'b1, 1'b0, 1'b0, 1'b0, "R6 rise");
      drive_watch(3, 1'b0, 1'b0, 1'b1, 1'b0, "R6 fall");
   endtask

   task automatic t_dual();
      wr(cfg_addr(3), 32'h7);
      settle();
      drive_watch(3, 1'b1, 1'b0, 1'b1, 1'b0, "R7 rise");
      drive_watch(3, 1'b0, 1'b0, 1'b1, 1'b0, "R7 fall");
   endtask

   task automatic t_undefined();
      wr(cfg_addr(3), 32'h1);
      settle();
      chk("R9", "code 001 low input", 32'(req[3]), 32'h0);
      wr(cfg_addr(3), 32'h5);
      drive_watch(3, 1'b1, 1'b0, 1'b0, 1'b0, "R9 code 101");
      wr(cfg_addr(3), 32'h3);
      drive_watch(3, 1'b0, 1'b0, 1'b0, 1'b0, "R9 code 011");
   endtask

   task automatic t_phantom();
      wr(cfg_addr(3), 32'h2);
      drive_watch(3, 1'b1, 1'b0, 1'b0, 1'b0, "R10 setup");
      settle();
      wr(cfg_addr(3), 32'h6);
      chk("R10", "falling to rising, write cycle", 32'(req[3]), 32'h0);
      @(negedge clk);
      chk("R10", "falling to rising, blanked cycle", 32'(req[3]), 32'h0);
      @(negedge clk);
      chk("R10", "falling to rising, after", 32'(req[3]), 32'h0);
      drive_watch(3, 1'b0, 1'b0, 1'b0, 1'b0, "R10 settle low");
      wr(cfg_addr(3), 32'h2);
      settle();
      wr(cfg_addr(3), 32'h7);
      @(negedge clk);
      chk("R10", "falling to both, blanked cycle", 32'(req[3]), 32'h0);
      @(negedge clk);
      chk("R10", "falling to both, after", 32'(req[3]), 32'h0);
      drive_watch(3, 1'b1, 1'b0, 1'b1, 1'b0, "R10 edge after blank");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_level_low();
      t_level_high();
      t_disabled();
      t_rising();
      t_falling();
      t_dual();
      t_undefined();
      t_phantom();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule